// File: doc/BRIEF.md
# Multi-Bank Quad PSRAM Burst Controller

This controller moves byte bursts between a simple request port and several quad-SPI pseudo-static RAM banks. All banks hang on one shared 4-bit data bus and one shared memory clock. Each bank is told apart only by its own active-low select line. A request carries a byte address, a byte count and a direction. The bank is taken from the address bits above the per-bank 16 MB window. The block then sends a command byte and a 24-bit device address as nibbles. For a read it waits out the device latency, and then it streams the data nibbles. Any burst that would run past a 1024-byte device page is cut at the page edge. The rest of the burst is sent as a fresh select/command/address transaction. This lets the memory run faster than cross-page streaming would allow.

One memory clock takes two system clocks: a low half, then a high half. Outputs change on the falling edge. Read nibbles are captured on the rising edge. The FSM states are IDLE, SETUP, CMD, WAIT, WDATA, RDATA and GAP. The transitions are:
- IDLE→SETUP when a request is accepted that is in range and has a non-zero length.
- SETUP→CMD always.
- CMD→WDATA for a write, or CMD→WAIT for a read, after the 8th command clock.
- WAIT→RDATA after the last wait clock.
- WDATA→GAP or RDATA→GAP after the last byte of the sub-burst.
- GAP→SETUP when bytes remain, or GAP→IDLE (with done) when the request is complete.

Out-of-range requests and zero-length requests stay in IDLE. They answer at once with err or done.

Top module: `psr_bank_ctrl`

## Requirements
- R1: After reset, all selects are high, mem_clk is low, mem_sio_oe is low and req_ready is high. rd_valid, done and err are all low.
- R2: Each transaction starts with 8 memory clocks, sent most significant nibble first. The first two carry the command byte: 0xEB for a read, 0x38 for a write. The next six carry the 24-bit in-bank byte address, which is address bits 23:0.
- R3: A read spends 12 wait clocks after the command phase, and the first data nibble is captured at the 21st rising edge. The first rd_valid therefore follows the select's falling edge by 43 system clocks. mem_sio_oe is low during the wait and read-data phases.
- R4: Read bytes arrive high nibble first, with one single-cycle rd_valid per byte. Bytes arrive every 2 memory clocks, which is 4 system clocks.
- R5: Writes are byte granular at any address and length. Each byte is pulled with one wr_ready strobe and sent high nibble first. Bytes next to the written range keep their contents.
- R6: A sub-burst holds min(remaining, 1024 − address mod 1024) bytes. The remainder goes out as new transactions, so no transaction crosses a 1024-byte page. A request that ends exactly on a page edge uses a single transaction.
- R7: The bank index is address bits 26:24, and bank k drives mem_cs_n[k]. At most one select is low at any time.
- R8: Between transactions, all selects stay high for at least one memory clock (2 system clocks). mem_clk stays low whenever no select is low.
- R9: done pulses exactly once, after the last sub-burst of a request, with all selects high. req_ready is low while a request is being served.
- R10: A request with address + length > 6 × 2^24 is rejected: err pulses once, there is no select activity and no done. A request that ends exactly at the top of the last bank is served.
- R11: A zero-length request in range answers with a done pulse and no select activity.
- R12: A burst that runs past a 16 MB bank edge continues at address 0 of the next bank, using that bank's select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 27 | Starting byte address (bits 26:24 pick the bank) |
| req_len | input | 16 | Byte count |
| wr_data | input | 8 | Write byte presented by the client |
| wr_ready | output | 1 | wr_data is taken at this clock edge |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | rd_data is valid (one cycle) |
| done | output | 1 | Request finished (one cycle) |
| err | output | 1 | Request rejected as out of range (one cycle) |
| mem_clk | output | 1 | Shared memory clock |
| mem_cs_n | output | 6 | Per-bank active-low selects |
| mem_sio_out | output | 4 | Nibble driven onto the shared bus |
| mem_sio_oe | output | 1 | Bus drive enable |
| mem_sio_in | input | 4 | Nibble read from the shared bus |

## Verification
Traffic is run against a behavioural nibble-bus memory that records every transaction. The bench uses short writes and reads inside one page to check the command codes, the address order, the 43-cycle read latency and the 4-cycle byte spacing. An odd-address write followed by a wider read-back separates true byte granularity from word behaviour. Bursts that start just below a page edge, a 2000-byte read that covers several pages, and a burst that ends exactly on an edge show whether the split point and the number of transactions are right. Bursts across a bank edge, into the top bank, past the top and with zero length check the bank decode, the range rejection and the immediate completion paths.

// File: rtl/psr_pkg.sv
package psr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_CMD,
        ST_WAIT,
        ST_WDATA,
        ST_RDATA,
        ST_GAP
    } psr_state_e;

    localparam logic [7:0] OPC_QREAD  = 8'hEB;
    localparam logic [7:0] OPC_QWRITE = 8'h38;
    localparam int         CMD_CLKS   = 8;

endpackage

// File: rtl/psr_bank_decode.sv
module psr_bank_decode #(
    parameter int NUM_BANKS = 6,
    parameter int BANK_AW   = 24,
    parameter int BSEL_W    = 3,
    parameter int ADDR_W    = 27,
    parameter int LEN_W     = 16
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [LEN_W-1:0]     len,
    output logic [NUM_BANKS-1:0] bank_oh,
    output logic                 range_ok
);
    localparam int             EW    = ADDR_W + 2;
    localparam logic [EW-1:0]  LIMIT = EW'(NUM_BANKS) << BANK_AW;

    logic [EW-1:0] end_x;

    assign end_x    = EW'(addr) + EW'(len);
    assign range_ok = (end_x <= LIMIT);

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_sel
        assign bank_oh[g] = (addr[ADDR_W-1:BANK_AW] == BSEL_W'(g));
    end
endmodule

// File: rtl/psr_page_split.sv
module psr_page_split #(
    parameter int PAGE_AW = 10,
    parameter int LEN_W   = 16
) (
    input  logic [PAGE_AW-1:0] page_off,
    input  logic [LEN_W-1:0]   remain,
    output logic [LEN_W-1:0]   sub_len
);
    localparam logic [PAGE_AW:0] PAGE_BYTES = (PAGE_AW+1)'(1) << PAGE_AW;

    logic [PAGE_AW:0] room;
    logic [LEN_W-1:0] room_w;

    assign room    = PAGE_BYTES - {1'b0, page_off};
    assign room_w  = LEN_W'(room);
    assign sub_len = (remain < room_w) ? remain : room_w;
endmodule

// File: rtl/psr_bank_ctrl.sv
module psr_bank_ctrl
    import psr_pkg::*;
#(
    parameter int NUM_BANKS = 6,
    parameter int BANK_AW   = 24,
    parameter int PAGE_AW   = 10,
    parameter int LEN_W     = 16,
    parameter int WAIT_CLKS = 12,
    localparam int BSEL_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ADDR_W   = BANK_AW + BSEL_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [LEN_W-1:0]     req_len,
    input  logic [7:0]           wr_data,
    output logic                 wr_ready,
    output logic [7:0]           rd_data,
    output logic                 rd_valid,
    output logic                 done,
    output logic                 err,
    output logic                 mem_clk,
    output logic [NUM_BANKS-1:0] mem_cs_n,
    output logic [3:0]           mem_sio_out,
    output logic                 mem_sio_oe,
    input  logic [3:0]           mem_sio_in
);
    localparam int CNT_W = $clog2((WAIT_CLKS > CMD_CLKS) ? WAIT_CLKS : CMD_CLKS) + 1;
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_CLKS - 1);
    localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_CLKS - 1);

    psr_state_e state, nxt;

    logic                 ph;
    logic                 nib;
    logic [CNT_W-1:0]     cnt;
    logic [31:0]          shreg;
    logic [ADDR_W-1:0]    cur_addr;
    logic [LEN_W-1:0]     rem;
    logic [LEN_W-1:0]     blen;
    logic                 is_wr;
    logic [7:0]           wbyte;
    logic [3:0]           rhi;

    logic                 mem_clk_q;
    logic [NUM_BANKS-1:0] cs_n_q;
    logic [3:0]           sio_q;
    logic                 oe_q;
    logic [7:0]           rd_data_q;
    logic                 rd_valid_q;
    logic                 done_q;
    logic                 err_q;

    logic [ADDR_W-1:0]    dec_addr;
    logic [LEN_W-1:0]     dec_len;
    logic [NUM_BANKS-1:0] bank_oh;
    logic                 range_ok;
    logic [LEN_W-1:0]     sub_len;
    logic [23:0]          dev_addr;
    logic [7:0]           opcode;
    logic                 cs_idle;

    assign dec_addr = (state == ST_IDLE) ? req_addr : cur_addr;
    assign dec_len  = (state == ST_IDLE) ? req_len  : rem;

    psr_bank_decode #(
        .NUM_BANKS(NUM_BANKS), .BANK_AW(BANK_AW), .BSEL_W(BSEL_W),
        .ADDR_W(ADDR_W), .LEN_W(LEN_W)
    ) u_decode (
        .addr(dec_addr), .len(dec_len), .bank_oh(bank_oh), .range_ok(range_ok)
    );

    psr_page_split #(.PAGE_AW(PAGE_AW), .LEN_W(LEN_W)) u_split (
        .page_off(cur_addr[PAGE_AW-1:0]), .remain(rem), .sub_len(sub_len)
    );

    assign dev_addr = 24'(cur_addr[BANK_AW-1:0]);
    assign opcode   = is_wr ? OPC_QWRITE : OPC_QREAD;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (req_valid && range_ok && req_len != '0) nxt = ST_SETUP;
            ST_SETUP: nxt = ST_CMD;
            ST_CMD:   if (ph && cnt == CMD_LAST) nxt = is_wr ? ST_WDATA : ST_WAIT;
            ST_WAIT:  if (ph && cnt == WAIT_LAST) nxt = ST_RDATA;
            ST_WDATA: if (ph && nib && blen == LEN_W'(1)) nxt = ST_GAP;
            ST_RDATA: if (ph && blen == '0) nxt = ST_GAP;
            ST_GAP:   if (ph) nxt = (rem == '0) ? ST_IDLE : ST_SETUP;
            default:  nxt = ST_IDLE;
        endcase
    end

    // ---------------- outputs and datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph <= 1'b0; nib <= 1'b0; cnt <= '0; shreg <= '0;
            cur_addr <= '0; rem <= '0; blen <= '0; is_wr <= 1'b0;
            wbyte <= '0; rhi <= '0;
            mem_clk_q <= 1'b0; cs_n_q <= '1; sio_q <= '0; oe_q <= 1'b0;
            rd_data_q <= '0; rd_valid_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
        end else begin
            rd_valid_q <= 1'b0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (!range_ok) begin
                            err_q <= 1'b1;
                        end else if (req_len == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            cur_addr <= req_addr;
                            rem      <= req_len;
                            is_wr    <= req_write;
                        end
                    end
                end
                ST_SETUP: begin
                    blen      <= sub_len;
                    sio_q     <= opcode[7:4];
                    shreg     <= {opcode[3:0], dev_addr, 4'h0};
                    cs_n_q    <= ~bank_oh;
                    oe_q      <= 1'b1;
                    mem_clk_q <= 1'b0;
                    ph        <= 1'b0;
                    cnt       <= '0;
                    nib       <= 1'b0;
                end
                ST_CMD: begin
                    if (!ph) begin
                        mem_clk_q <= 1'b1;
                        ph        <= 1'b1;
                    end else begin
                        mem_clk_q <= 1'b0;
                        ph        <= 1'b0;
                        if (cnt == CMD_LAST) begin
                            cnt <= '0;
                            nib <= 1'b0;
                            if (is_wr) begin
                                wbyte <= wr_data;
                                sio_q <= wr_data[7:4];
                            end else begin
                                oe_q  <= 1'b0;
                                sio_q <= '0;
                            end
                        end else begin
                            cnt   <= cnt + CNT_W'(1);
                            sio_q <= shreg[31:28];
                            shreg <= shreg << 4;
                        end
                    end
                end
                ST_WAIT: begin
                    if (!ph) begin
                        mem_clk_q <= 1'b1;
                        ph        <= 1'b1;
                    end else begin
                        mem_clk_q <= 1'b0;
                        ph        <= 1'b0;
                        cnt       <= (cnt == WAIT_LAST) ? '0 : cnt + CNT_W'(1);
                    end
                end
                ST_WDATA: begin
                    if (!ph) begin
                        mem_clk_q <= 1'b1;
                        ph        <= 1'b1;
                    end else begin
                        mem_clk_q <= 1'b0;
                        ph        <= 1'b0;
                        if (!nib) begin
                            sio_q <= wbyte[3:0];
                            nib   <= 1'b1;
                        end else begin
                            nib      <= 1'b0;
                            cur_addr <= cur_addr + ADDR_W'(1);
                            rem      <= rem - LEN_W'(1);
                            if (blen == LEN_W'(1)) begin
                                blen   <= '0;
                                cs_n_q <= '1;
                                oe_q   <= 1'b0;
                                sio_q  <= '0;
                            end else begin
                                blen  <= blen - LEN_W'(1);
                                wbyte <= wr_data;
                                sio_q <= wr_data[7:4];
                            end
                        end
                    end
                end
                ST_RDATA: begin
                    if (!ph) begin
                        mem_clk_q <= 1'b1;
                        ph        <= 1'b1;
                        if (!nib) begin
                            rhi <= mem_sio_in;
                            nib <= 1'b1;
                        end else begin
                            rd_data_q  <= {rhi, mem_sio_in};
                            rd_valid_q <= 1'b1;
                            nib        <= 1'b0;
                            blen       <= blen - LEN_W'(1);
                            cur_addr   <= cur_addr + ADDR_W'(1);
                            rem        <= rem - LEN_W'(1);
                        end
                    end else begin
                        mem_clk_q <= 1'b0;
                        ph        <= 1'b0;
                        if (blen == '0) cs_n_q <= '1;
                    end
                end
                ST_GAP: begin
                    mem_clk_q <= 1'b0;
                    if (!ph) begin
                        ph <= 1'b1;
                    end else begin
                        ph <= 1'b0;
                        if (rem == '0) done_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign req_ready   = (state == ST_IDLE);
    assign wr_ready    = (state == ST_CMD && ph && cnt == CMD_LAST && is_wr) ||
                         (state == ST_WDATA && ph && nib && blen != LEN_W'(1));
    assign rd_data     = rd_data_q;
    assign rd_valid    = rd_valid_q;
    assign done        = done_q;
    assign err         = err_q;
    assign mem_clk     = mem_clk_q;
    assign mem_cs_n    = cs_n_q;
    assign mem_sio_out = sio_q;
    assign mem_sio_oe  = oe_q;
    assign cs_idle     = &cs_n_q;

    // ---------------- assertions ----------------
    logic [LEN_W:0] split_end;
    assign split_end = (LEN_W+1)'(cur_addr[PAGE_AW-1:0]) + (LEN_W+1)'(sub_len);

    // R7
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n));

    // R8
    clk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_idle |-> !mem_clk);

    // R8
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_idle) |=> cs_idle);

    // R3
    bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT || state == ST_RDATA) |-> !mem_sio_oe);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_idle && !err));

    // R4
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R6
    split_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETUP) |-> (sub_len != '0 && sub_len <= rem &&
                                 split_end <= ((LEN_W+1)'(1) << PAGE_AW)));

    // R10
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (cs_idle && req_ready));
endmodule

// File: tb/psr_bank_ctrl_bench.sv
module psr_bank_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [26:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic [7:0]  wr_data;
    logic        wr_ready;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        done;
    logic        err;
    logic        mem_clk;
    logic [5:0]  mem_cs_n;
    logic [3:0]  mem_sio_out;
    logic        mem_sio_oe;
    logic [3:0]  mem_sio_in = '0;

    always #10 clk = ~clk;

    psr_bank_ctrl u_psr_bank_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len),
        .wr_data(wr_data), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .err(err),
        .mem_clk(mem_clk), .mem_cs_n(mem_cs_n), .mem_sio_out(mem_sio_out),
        .mem_sio_oe(mem_sio_oe), .mem_sio_in(mem_sio_in)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] init_byte(input int unsigned a);
        int unsigned t;
        t = a ^ (a >> 8) ^ (a >> 17);
        return t[7:0] ^ 8'h5A;
    endfunction

    // ---------------- behavioural memory on the shared nibble bus ----------------
    logic [7:0]  mem_arr [int unsigned];
    int          rise_cnt = 0;
    logic [7:0]  m_cmd = '0;
    logic [23:0] m_addr = '0;
    int          m_bank = 0;
    logic [3:0]  hi_n = '0;
    int          viol_cs = 0, viol_clk = 0, viol_oe = 0, viol_cmd = 0, viol_page = 0;
    int          tx_cnt = 0;
    int unsigned tx_start [0:15];
    int          tx_len   [0:15];
    int          tx_bank  [0:15];
    logic [7:0]  tx_cmd   [0:15];
    wire         cs_idle = &mem_cs_n;

    function automatic logic [7:0] mem_rd(input int unsigned a);
        if (mem_arr.exists(a)) return mem_arr[a];
        return init_byte(a);
    endfunction

    always @(posedge mem_clk) begin
        if (cs_idle) begin
            viol_clk++;
        end else begin
            rise_cnt++;
            if ($countones(~mem_cs_n) != 1) viol_cs++;
            for (int i = 0; i < 6; i++) if (!mem_cs_n[i]) m_bank = i;
            if (rise_cnt <= 2) begin
                m_cmd = {m_cmd[3:0], mem_sio_out};
                if (!mem_sio_oe) viol_oe++;
            end else if (rise_cnt <= 8) begin
                m_addr = {m_addr[19:0], mem_sio_out};
                if (!mem_sio_oe) viol_oe++;
            end else if (m_cmd == 8'h38) begin
                if (!mem_sio_oe) viol_oe++;
                if (((rise_cnt - 9) % 2) == 0) hi_n = mem_sio_out;
                else mem_arr[int'(m_bank) * 32'h0100_0000 + int'(m_addr) + (rise_cnt - 9) / 2]
                         = {hi_n, mem_sio_out};
            end else if (m_cmd == 8'hEB) begin
                if (mem_sio_oe) viol_oe++;
            end else begin
                viol_cmd++;
            end
        end
    end

    always @(negedge mem_clk) begin
        if (!cs_idle && m_cmd == 8'hEB && rise_cnt >= 20) begin
            automatic int k = rise_cnt - 20;
            automatic logic [7:0] b =
                mem_rd(int'(m_bank) * 32'h0100_0000 + int'(m_addr) + k / 2);
            mem_sio_in = (k % 2 == 0) ? b[7:4] : b[3:0];
        end
    end

    always @(posedge cs_idle) begin
        if (rise_cnt > 0) begin
            automatic int nb = (m_cmd == 8'h38) ? (rise_cnt - 8) / 2 : (rise_cnt - 20) / 2;
            if ((int'(m_addr) % 1024) + nb > 1024) viol_page++;
            if (tx_cnt < 16) begin
                tx_start[tx_cnt] = int'(m_bank) * 32'h0100_0000 + int'(m_addr);
                tx_len[tx_cnt]   = nb;
                tx_bank[tx_cnt]  = m_bank;
                tx_cmd[tx_cnt]   = m_cmd;
            end
            tx_cnt++;
        end
        rise_cnt = 0;
        m_cmd    = '0;
        m_addr   = '0;
    end

    // ---------------- client side ----------------
    logic [7:0] wbuf [0:2047];
    logic [7:0] rbuf [0:2047];
    int         wr_idx = 0;
    int         rd_cnt = 0;
    int         wr_pulls = 0;
    int         done_cnt = 0, err_cnt = 0;
    longint     cyc = 0;
    longint     first_cs = -1;
    longint     rv_cyc [0:3];
    int         hi_run = 0;
    int         min_gap = 999;
    logic       prev_idle = 1'b1;
    logic       ready_after = 1'b0;

    assign wr_data = wbuf[wr_idx[10:0]];

    always @(posedge clk) if (wr_ready) wr_idx <= wr_idx + 1;

    always @(negedge clk) begin
        cyc++;
        if (wr_ready) wr_pulls++;
        if (rd_valid) begin
            if (rd_cnt < 4) rv_cyc[rd_cnt] = cyc;
            rbuf[rd_cnt[10:0]] = rd_data;
            rd_cnt++;
        end
        if (done) done_cnt++;
        if (err)  err_cnt++;
        if (cs_idle) begin
            hi_run++;
        end else begin
            if (prev_idle && first_cs < 0) first_cs = cyc;
            if (prev_idle && hi_run < min_gap) min_gap = hi_run;
            hi_run = 0;
        end
        prev_idle = cs_idle;
    end

    task automatic do_req(input logic wr, input int unsigned addr, input int len);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        wr_idx = 0; rd_cnt = 0; wr_pulls = 0; done_cnt = 0; err_cnt = 0;
        first_cs = -1; min_gap = 999; hi_run = 0;
        req_valid = 1'b1; req_write = wr; req_addr = addr[26:0]; req_len = len[15:0];
        @(negedge clk);
        req_valid = 1'b0;
        ready_after = req_ready;
        for (int t = 0; t < 20000 && done_cnt == 0 && err_cnt == 0; t++) @(negedge clk);
        if (done_cnt == 0 && err_cnt == 0) chk("request timeout", 0, 1);
        repeat (6) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R1 selects high", mem_cs_n, 6'h3F);
        chk("R1 mem_clk low", mem_clk, 0);
        chk("R1 oe low", mem_sio_oe, 0);
        chk("R1 ready high", req_ready, 1);
        chk("R1 strobes low", {rd_valid, done, err}, 0);
    endtask

    task automatic t_small_write_read();
        int tx0;
        for (int i = 0; i < 4; i++) wbuf[i] = 8'hA0 + 8'(i * 17);
        tx0 = tx_cnt;
        do_req(1'b1, 32'h0000_0100, 4);
        chk("R2 write tx count", tx_cnt - tx0, 1);
        chk("R2 write opcode 0x38", tx_cmd[tx0], 8'h38);
        chk("R2 write address", tx_start[tx0], 32'h100);
        chk("R5 write pulls", wr_pulls, 4);
        for (int i = 0; i < 4; i++) chk("R5 stored byte", mem_rd(32'h100 + i), wbuf[i]);
        chk("R9 busy while serving", ready_after, 0);
        chk("R9 single done", done_cnt, 1);
        tx0 = tx_cnt;
        do_req(1'b0, 32'h0000_0100, 4);
        chk("R2 read opcode 0xEB", tx_cmd[tx0], 8'hEB);
        chk("R4 read count", rd_cnt, 4);
        for (int i = 0; i < 4; i++) chk("R4 read byte", rbuf[i], wbuf[i]);
        chk("R3 first byte latency", rv_cyc[0] - first_cs, 43);
        chk("R4 byte spacing", rv_cyc[1] - rv_cyc[0], 4);
        chk("R4 byte spacing 2", rv_cyc[3] - rv_cyc[2], 4);
        chk("R3 bus released in wait/read", viol_oe, 0);
    endtask

    task automatic t_byte_granular();
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        do_req(1'b1, 32'h0000_0805, 3);
        do_req(1'b0, 32'h0000_0803, 7);
        chk("R5 lower neighbour", rbuf[1], init_byte(32'h804));
        chk("R5 byte at odd addr", rbuf[2], 8'h11);
        chk("R5 byte 2", rbuf[3], 8'h22);
        chk("R5 byte 3", rbuf[4], 8'h33);
        chk("R5 upper neighbour", rbuf[5], init_byte(32'h808));
    endtask

    task automatic t_page_split();
        int tx0;
        int bad;
        for (int i = 0; i < 10; i++) wbuf[i] = 8'(8'h40 + i);
        tx0 = tx_cnt;
        do_req(1'b1, 32'h0100_03FC, 10);
        chk("R6 write split count", tx_cnt - tx0, 2);
        chk("R6 first part length", tx_len[tx0], 4);
        chk("R6 second part start", tx_start[tx0 + 1], 32'h0100_0400);
        chk("R6 second part length", tx_len[tx0 + 1], 6);
        chk("R8 gap between parts", (min_gap >= 2) ? 1 : 0, 1);
        chk("R9 one done for split", done_cnt, 1);
        for (int i = 0; i < 10; i++) chk("R6 split data", mem_rd(32'h0100_03FC + i), wbuf[i]);
        tx0 = tx_cnt;
        do_req(1'b0, 32'h0200_0010, 2000);
        chk("R6 long read parts", tx_cnt - tx0, 2);
        chk("R6 long read first len", tx_len[tx0], 1008);
        chk("R4 long read count", rd_cnt, 2000);
        bad = 0;
        for (int i = 0; i < 2000; i++) if (rbuf[i] != init_byte(32'h0200_0010 + i)) bad++;
        chk("R4 long read data", bad, 0);
        tx0 = tx_cnt;
        do_req(1'b0, 32'h0000_0200, 512);
        chk("R6 exact edge single tx", tx_cnt - tx0, 1);
        chk("R6 no page crossing", viol_page, 0);
    endtask

    task automatic t_banks();
        int tx0;
        wbuf[0] = 8'hC1; wbuf[1] = 8'hC2; wbuf[2] = 8'hC3; wbuf[3] = 8'hC4;
        tx0 = tx_cnt;
        do_req(1'b1, 32'h00FF_FFFE, 4);
        chk("R12 cross-bank parts", tx_cnt - tx0, 2);
        chk("R12 first bank", tx_bank[tx0], 0);
        chk("R12 second bank", tx_bank[tx0 + 1], 1);
        chk("R12 second start", tx_start[tx0 + 1], 32'h0100_0000);
        chk("R12 data in bank1", mem_rd(32'h0100_0001), 8'hC4);
        tx0 = tx_cnt;
        do_req(1'b0, 32'h05FF_FFFE, 2);
        chk("R10 top bytes served", done_cnt, 1);
        chk("R7 top bank select", tx_bank[tx0], 5);
        chk("R7 single select", viol_cs, 0);
        chk("R8 no clock while idle", viol_clk, 0);
    endtask

    task automatic t_reject();
        int tx0;
        tx0 = tx_cnt;
        do_req(1'b0, 32'h0600_0000, 4);
        chk("R10 err for bank 6", err_cnt, 1);
        chk("R10 no done", done_cnt, 0);
        chk("R10 no transaction", tx_cnt - tx0, 0);
        do_req(1'b1, 32'h05FF_FFFE, 4);
        chk("R10 err past top", err_cnt, 1);
        chk("R10 no pulls", wr_pulls, 0);
        chk("R10 still no transaction", tx_cnt - tx0, 0);
        do_req(1'b0, 32'h0000_0040, 0);
        chk("R11 zero length done", done_cnt, 1);
        chk("R11 zero length no err", err_cnt, 0);
        chk("R11 zero length no transaction", tx_cnt - tx0, 0);
        chk("R2 command codes valid", viol_cmd, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_small_write_read();
        t_byte_granular();
        t_page_split();
        t_banks();
        t_reject();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule